// File: doc/BRIEF.md
# Sampling Window Tuning Engine

The engine searches for the most reliable clock-sample delay of a storage interface. On a tune command it walks every delay code from 1 up to 127. For each code it asks the delay hardware to load the code through a request/acknowledge handshake. It then asks an external test agent, through a second handshake, to run one tuning transfer and report pass or fail. While walking, it tracks the longest stretch of consecutive passing codes. At the end it loads the centre of that stretch into the clock-sample delay and reports the result of that last load as its final status.

A second command, preset, loads a fixed read-strobe delay of 32 codes, which is a quarter-period (90 degree) shift. It reports whether that load succeeded. The engine does not implement the tuning transfer or the delay line. It reaches both only through the two handshakes.

Top module: `tune_window_engine`

## Requirements
- R1: After reset, busy, done, err, no_window, dly_req and test_req are 0, and best_code, best_start and best_end are 0.
- R2: A tune command loads the codes 1, 2, ... 127 in increasing order with dly_sel = 0 (clock-sample delay), and then performs exactly one further clock-sample load, which carries the chosen code.
- R3: A request (dly_req or test_req) stays high, with dly_code and dly_sel unchanged, until its acknowledge is seen. dly_req and test_req are never high together.
- R4: A code passes only if its load is acknowledged with dly_err = 0 and its test is acknowledged with test_fail = 0. A load error marks the code as failing, and no test is requested for that code.
- R5: A failing code closes the open window, and the window's end is the previous code. The next passing code opens a new window. The reported window always satisfies best_end >= best_start.
- R6: A closed window replaces the best one only if its length (end minus start) is strictly greater than the best length so far, which starts at 0. On equal lengths the earlier window is kept. As a result, a window must span at least two codes to be chosen.
- R7: The chosen code best_code is (best_start + best_end) >> 1.
- R8: A window still open after code 127 is closed with end = 127 and compared like any other window.
- R9: After the sweep, the chosen code is loaded. done pulses for one cycle with busy = 0, and err equals the dly_err of that final load.
- R10: If no window is chosen, best_code, best_start and best_end are 0, no_window is 1 after done, and code 0 is still loaded as the final step.
- R11: A preset command performs a single load with dly_sel = 1 and dly_code = 32. done then pulses, err equals that load's dly_err, and the tuning results stay unchanged.
- R12: While busy, both start_tune and start_preset are ignored. If both commands arrive in the same idle cycle, tune wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_tune | input | 1 | Start a full delay sweep (one-cycle pulse) |
| start_preset | input | 1 | Load the fixed read-strobe delay (one-cycle pulse) |
| dly_req | output | 1 | Delay load request |
| dly_sel | output | 1 | Delay target: 0 clock-sample, 1 read-strobe |
| dly_code | output | 7 | Delay code to load |
| dly_ack | input | 1 | Delay load acknowledge (one-cycle pulse) |
| dly_err | input | 1 | Load failed; valid with dly_ack |
| test_req | output | 1 | Tuning test request |
| test_ack | input | 1 | Tuning test acknowledge (one-cycle pulse) |
| test_fail | input | 1 | Test reported an error; valid with test_ack |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status of the last completed command |
| no_window | output | 1 | The last tune found no usable window |
| best_code | output | 7 | Chosen delay code |
| best_start | output | 7 | First code of the chosen window |
| best_end | output | 7 | Last code of the chosen window |

## Verification
Directed pass maps cover cases that each separate one rule. An all-fail map and a map of isolated single passes both test the no-window outcome. Two equal windows show that the earlier window is kept. A window reaching code 127 shows the closing at the end of the sweep. A window cut by a load error shows that load failures count as test failures. Random maps, built from runs of random length, mix many windows and load errors and are compared against a bench model that scans for maximal runs. The handshake latency is varied between runs, so the ordering and holding rules are exercised at more than one speed.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_TEST, ST_FINAL, ST_PRESET
  } tune_state_e;

  // Window length as the span end minus start.
  function automatic int unsigned win_len(input int unsigned s, input int unsigned e);
    return e - s;
  endfunction

  // Centre of a window, rounded down.
  function automatic int unsigned mid_code(input int unsigned s, input int unsigned e);
    return (s + e) >> 1;
  endfunction
endpackage

// File: rtl/tune_window_tracker.sv
module tune_window_tracker #(
  parameter int CODE_W    = 7,
  parameter int LAST_CODE = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              pass,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] best_start,
  output logic [CODE_W-1:0] best_end,
  output logic [CODE_W-1:0] best_code,
  output logic              found
);
  import tune_pkg::*;

  logic              open_q;
  logic [CODE_W-1:0] cur_start_q;
  logic [CODE_W-1:0] best_len_q;
  logic              close_now;
  logic [CODE_W-1:0] cand_s, cand_e;
  logic              better;

  always_comb begin
    close_now = step && ((!pass && open_q) || (pass && code == CODE_W'(LAST_CODE)));
    cand_s    = (pass && !open_q) ? code : cur_start_q;
    cand_e    = pass ? code : code - 1'b1;
    better    = close_now && (win_len(cand_s, cand_e) > int'(best_len_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; cur_start_q <= '0; best_len_q <= '0;
      best_start <= '0; best_end <= '0; best_code <= '0; found <= 1'b0;
    end else if (clear) begin
      open_q <= 1'b0; cur_start_q <= '0; best_len_q <= '0;
      best_start <= '0; best_end <= '0; best_code <= '0; found <= 1'b0;
    end else if (step) begin
      if (pass && !open_q) begin
        open_q      <= 1'b1;
        cur_start_q <= code;
      end else if (!pass) begin
        open_q <= 1'b0;
      end
      if (better) begin
        best_start <= cand_s;
        best_end   <= cand_e;
        best_len_q <= CODE_W'(win_len(cand_s, cand_e));
        best_code  <= CODE_W'(mid_code(cand_s, cand_e));
        found      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tune_sequencer.sv
module tune_sequencer #(
  parameter int CODE_W      = 7,
  parameter int FIRST_CODE  = 1,
  parameter int LAST_CODE   = 127,
  parameter int PRESET_CODE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_tune,
  input  logic              start_preset,
  input  logic              dly_ack,
  input  logic              dly_err,
  input  logic              test_ack,
  input  logic              test_fail,
  input  logic [CODE_W-1:0] chosen_code,
  output logic              dly_req,
  output logic              dly_sel,
  output logic [CODE_W-1:0] dly_code,
  output logic              test_req,
  output logic              step_valid,
  output logic              step_pass,
  output logic [CODE_W-1:0] step_code,
  output logic              clear,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              have_result
);
  import tune_pkg::*;

  tune_state_e       state_q;
  logic [CODE_W-1:0] code_q;
  logic              last_code;

  always_comb begin
    last_code  = (code_q == CODE_W'(LAST_CODE));
    busy       = (state_q != ST_IDLE);
    dly_req    = (state_q == ST_PROG) || (state_q == ST_FINAL) || (state_q == ST_PRESET);
    test_req   = (state_q == ST_TEST);
    dly_sel    = (state_q == ST_PRESET);
    case (state_q)
      ST_FINAL:  dly_code = chosen_code;
      ST_PRESET: dly_code = CODE_W'(PRESET_CODE);
      default:   dly_code = code_q;
    endcase
    step_valid = ((state_q == ST_PROG) && dly_ack && dly_err) ||
                 ((state_q == ST_TEST) && test_ack);
    step_pass  = (state_q == ST_TEST) && !test_fail;
    step_code  = code_q;
    clear      = (state_q == ST_IDLE) && start_tune;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; code_q <= '0; done <= 1'b0; err <= 1'b0; have_result <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_tune) begin
            state_q     <= ST_PROG;
            code_q      <= CODE_W'(FIRST_CODE);
            err         <= 1'b0;
            have_result <= 1'b0;
          end else if (start_preset) begin
            state_q <= ST_PRESET;
            err     <= 1'b0;
          end
        end
        ST_PROG: begin
          if (dly_ack) begin
            if (!dly_err)       state_q <= ST_TEST;
            else if (last_code) state_q <= ST_FINAL;
            else                code_q  <= code_q + 1'b1;
          end
        end
        ST_TEST: begin
          if (test_ack) begin
            if (last_code) state_q <= ST_FINAL;
            else begin
              state_q <= ST_PROG;
              code_q  <= code_q + 1'b1;
            end
          end
        end
        ST_FINAL: begin
          if (dly_ack) begin
            state_q     <= ST_IDLE;
            done        <= 1'b1;
            err         <= dly_err;
            have_result <= 1'b1;
          end
        end
        ST_PRESET: begin
          if (dly_ack) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            err     <= dly_err;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tune_window_engine.sv
module tune_window_engine #(
  parameter int CODE_W      = 7,
  parameter int FIRST_CODE  = 1,
  parameter int LAST_CODE   = 127,
  parameter int PRESET_CODE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_tune,
  input  logic              start_preset,
  output logic              dly_req,
  output logic              dly_sel,
  output logic [CODE_W-1:0] dly_code,
  input  logic              dly_ack,
  input  logic              dly_err,
  output logic              test_req,
  input  logic              test_ack,
  input  logic              test_fail,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              no_window,
  output logic [CODE_W-1:0] best_code,
  output logic [CODE_W-1:0] best_start,
  output logic [CODE_W-1:0] best_end
);
  // Internal events, named for the checker.
  logic              step_valid;
  logic              step_pass;
  logic [CODE_W-1:0] step_code;
  logic              clear;
  logic              found;
  logic              have_result;

  tune_sequencer #(
    .CODE_W(CODE_W), .FIRST_CODE(FIRST_CODE),
    .LAST_CODE(LAST_CODE), .PRESET_CODE(PRESET_CODE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_tune(start_tune), .start_preset(start_preset),
    .dly_ack(dly_ack), .dly_err(dly_err), .test_ack(test_ack), .test_fail(test_fail),
    .chosen_code(best_code), .dly_req(dly_req), .dly_sel(dly_sel), .dly_code(dly_code),
    .test_req(test_req), .step_valid(step_valid), .step_pass(step_pass),
    .step_code(step_code), .clear(clear), .busy(busy), .done(done), .err(err),
    .have_result(have_result)
  );

  tune_window_tracker #(.CODE_W(CODE_W), .LAST_CODE(LAST_CODE)) u_trk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step_valid), .pass(step_pass),
    .code(step_code), .best_start(best_start), .best_end(best_end),
    .best_code(best_code), .found(found)
  );

  assign no_window = have_result && !found;
endmodule

// File: rtl/tune_window_checker.sv
module tune_window_checker #(
  parameter int CODE_W      = 7,
  parameter int PRESET_CODE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dly_req,
  input logic              dly_sel,
  input logic [CODE_W-1:0] dly_code,
  input logic              dly_ack,
  input logic              dly_err,
  input logic              test_req,
  input logic              test_ack,
  input logic              busy,
  input logic              done,
  input logic              no_window,
  input logic [CODE_W-1:0] best_code,
  input logic [CODE_W-1:0] best_start,
  input logic [CODE_W-1:0] best_end
);
  p_dly_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dly_req && !dly_ack |=> dly_req && $stable(dly_code) && $stable(dly_sel));
  p_test_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && !test_ack |=> test_req);
  p_req_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_req && test_req));
  p_test_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_req) |-> $past(dly_ack && !dly_err));
  p_window_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    best_end >= best_start);
  p_centre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> best_code == CODE_W'((int'(best_start) + int'(best_end)) / 2));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !dly_req && !test_req);
  p_no_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    no_window |-> best_code == '0 && best_start == '0 && best_end == '0);
  p_preset_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dly_req && dly_sel |-> dly_code == CODE_W'(PRESET_CODE));
endmodule

bind tune_window_engine tune_window_checker #(.CODE_W(CODE_W), .PRESET_CODE(PRESET_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .dly_req(dly_req), .dly_sel(dly_sel), .dly_code(dly_code),
  .dly_ack(dly_ack), .dly_err(dly_err), .test_req(test_req), .test_ack(test_ack),
  .busy(busy), .done(done), .no_window(no_window), .best_code(best_code),
  .best_start(best_start), .best_end(best_end)
);

// File: tb/tb_tune_window_engine.sv
`timescale 1ns/1ps
module tb_tune_window_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_tune = 1'b0, start_preset = 1'b0;
  logic       dly_req, dly_sel, test_req, busy, done, err, no_window;
  logic [6:0] dly_code, best_code, best_start, best_end;
  logic       dly_ack = 1'b0, dly_err = 1'b0, test_ack = 1'b0, test_fail = 1'b0;

  int n_tests = 0, n_fail = 0;

  tune_window_engine dut (
    .clk(clk), .rst_n(rst_n), .start_tune(start_tune), .start_preset(start_preset),
    .dly_req(dly_req), .dly_sel(dly_sel), .dly_code(dly_code), .dly_ack(dly_ack),
    .dly_err(dly_err), .test_req(test_req), .test_ack(test_ack), .test_fail(test_fail),
    .busy(busy), .done(done), .err(err), .no_window(no_window),
    .best_code(best_code), .best_start(best_start), .best_end(best_end)
  );

  always #4 clk = ~clk;

  // Responder state
  bit [127:0] pass_v, perr_v;
  bit         final_err_b, preset_err_b;
  int         lat = 1, dcnt = 0, tcnt = 0;
  int         n_sweep = 0, n_final = 0, n_preset = 0, n_tests_req = 0, seq_bad = 0;
  int         last_final_code = -1, cur_code = 0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      dly_ack = 0; test_ack = 0; dly_err = 0; test_fail = 0;
      if (dly_req) begin
        if (dcnt >= lat) begin
          dcnt = 0; dly_ack = 1;
          if (dly_sel) begin
            n_preset++; dly_err = preset_err_b;
          end else if (n_sweep < 127) begin
            if (int'(dly_code) != n_sweep + 1) seq_bad++;
            n_sweep++; cur_code = dly_code; dly_err = perr_v[dly_code];
          end else begin
            n_final++; last_final_code = dly_code; dly_err = final_err_b;
          end
        end else dcnt++;
      end
      if (test_req) begin
        if (tcnt >= lat) begin
          tcnt = 0; test_ack = 1; n_tests_req++;
          test_fail = !pass_v[cur_code];
        end else tcnt++;
      end
    end
  end

  // Bench model: scan maximal runs of usable codes, keep the first longest (span > 0).
  task automatic model(input bit [127:0] ok, output int s, output int e, output int c, output bit f);
    int run_s, best;
    s = 0; e = 0; c = 0; f = 0; best = 0; run_s = -1;
    for (int k = 1; k <= 128; k++) begin
      bit good;
      good = (k <= 127) && ok[k];
      if (good && run_s < 0) run_s = k;
      else if (!good && run_s >= 0) begin
        if ((k - 1) - run_s > best) begin
          best = (k - 1) - run_s; s = run_s; e = k - 1; c = (s + e) / 2; f = 1;
        end
        run_s = -1;
      end
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic run_tune(input string name, input bit [127:0] pv, input bit [127:0] ev,
                          input bit fe, input bit poke);
    int s, e, c, passing; bit f;
    pv[0] = 0; ev[0] = 0;
    pass_v = pv; perr_v = ev; final_err_b = fe;
    n_sweep = 0; n_final = 0; n_preset = 0; n_tests_req = 0; seq_bad = 0;
    last_final_code = -1; dcnt = 0; tcnt = 0;
    @(negedge clk); start_tune = 1; @(negedge clk); start_tune = 0;
    if (poke) begin
      repeat (60) @(negedge clk);
      start_preset = 1; start_tune = 1; @(negedge clk); start_preset = 0; start_tune = 0;
    end
    wait_done();
    model(pv & ~ev, s, e, c, f);
    passing = $countones(~ev[127:1]);
    $display("[TB] %s", name);
    check("R2 sweep order", seq_bad, 0);
    check("R2 sweep count", n_sweep, 127);
    check("R4 tests only after clean load", n_tests_req, passing);
    check("R5 window start", best_start, s);
    check("R6/R8 window end", best_end, e);
    check("R7 chosen code", best_code, c);
    check("R9 final load code", last_final_code, c);
    check("R9 final load count", n_final, 1);
    check("R9 err from final load", err, fe);
    check("R9 not busy at done", busy, 0);
    check("R10 no_window flag", no_window, !f);
    if (poke) check("R12 preset ignored while busy", n_preset, 0);
    @(negedge clk);
    check("R9 done is a single pulse", done, 0);
  endtask

  task automatic run_preset(input bit pe);
    int bc;
    bc = best_code; preset_err_b = pe; n_preset = 0; n_final = 0; dcnt = 0;
    @(negedge clk); start_preset = 1; @(negedge clk); start_preset = 0;
    wait_done();
    check("R11 preset load count", n_preset, 1);
    check("R11 preset err", err, pe);
    check("R11 results unchanged", best_code, bc);
    check("R11 no clock-sample load", n_final, 0);
  endtask

  function automatic bit [127:0] span(input int a, input int b);
    bit [127:0] v = '0;
    for (int k = a; k <= b; k++) v[k] = 1'b1;
    return v;
  endfunction

  function automatic bit [127:0] rand_map(input int bias);
    bit [127:0] v = '0; bit cur = 0; int k = 1;
    while (k <= 127) begin
      int len = 1 + ($urandom % 12);
      for (int j = 0; j < len && k <= 127; j++) begin v[k] = cur; k++; end
      cur = (($urandom % 100) < bias) ? 1'b1 : 1'b0;
    end
    return v;
  endfunction

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);       check("R1 done", done, 0);
    check("R1 err", err, 0);         check("R1 no_window", no_window, 0);
    check("R1 dly_req", dly_req, 0); check("R1 test_req", test_req, 0);
    check("R1 best_code", best_code, 0);
    check("R1 bounds", best_start + best_end, 0);
    rst_n = 1;
    lat = 0; run_tune("all fail (R10)", '0, '0, 0, 0);
    lat = 1; run_tune("single window 40..60 (R5 R7)", span(40, 60), '0, 0, 0);
    lat = 2; run_tune("equal windows keep earlier (R6)", span(10, 20) | span(50, 60), '0, 0, 0);
    lat = 0; run_tune("open at end (R8)", span(5, 8) | span(100, 127), '0, 0, 0);
    lat = 1; run_tune("load errors split window (R4)", span(20, 90), span(50, 50) | span(51, 51), 0, 0);
    lat = 1; run_tune("isolated passes only (R6 R10)", span(3, 3) | span(9, 9) | span(77, 77), '0, 0, 0);
    lat = 0; run_tune("all pass with final err (R8 R9)", span(1, 127), '0, 1, 0);
    lat = 2; run_tune("commands ignored while busy (R12)", span(30, 45), '0, 0, 1);
    run_preset(0);
    run_preset(1);
    for (int i = 0; i < 6; i++) begin
      lat = $urandom % 3;
      run_tune("random map", rand_map(55), rand_map(8) & rand_map(30), 1'($urandom % 2), 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule